// File: doc/BRIEF.md
# Cascadable Lookup Table Slice

This block is one programmable logic slice holding two 4-input lookup tables. Each table stores a 16-entry truth table, so loading the right bits makes it compute any Boolean function of its four inputs. The two truth tables are loaded either in one cycle through a parallel word port or bit by bit through a shift port while a shift enable is held high. Until a load has completed correctly the function outputs are held low and a configuration-ready flag stays low.

Inside the slice a 2:1 multiplexer driven by a fifth input picks between the two table outputs, forming a 5-input function. A second multiplexer with two cascade inputs and its own select lets slices be chained into a tree: two slices make a 6-input function, four make a 7-input function, and eight make an 8-input function, which is why an 8-input function needs more than four slices.

Top module: `lut_slice`

## Requirements
- R1: Each table output equals bit `i` of its 16-bit truth table, where `i` is the table's 4-bit input with input bit 0 as the least significant address bit; table A takes configuration bits 15:0 and table B takes bits 31:16.
- R2: The two tables have independent inputs and independent contents, and any 16-bit pattern (constant zero, constant one, AND, parity, random) is reproduced exactly.
- R3: When configured, the 5-input output equals table B's output when the fifth input is 1 and table A's output when it is 0.
- R4: The cascade output equals the high cascade input when the cascade select is 1 and the low cascade input when it is 0, at all times.
- R5: A parallel write stores the 32-bit word into both tables and raises the ready flag in the cycle after the write; the flag then stays high until a new load begins.
- R6: Each cycle with shift enable high moves the serial bit into configuration bit 31 and every other bit down by one, so the first bit sent ends in bit 0; the ready flag rises after the first clock edge with shift enable low that follows exactly 32 shift cycles.
- R7: While shifting, after reset, and after a shift burst of any length other than 32, the ready flag is low and the table and 5-input outputs are 0.
- R8: A parallel write in the same cycle as shift enable takes priority: the word is stored and the ready flag rises.
- R9: Two slices, with the second slice's 5-input output on the first slice's high cascade input and the first slice's own 5-input output on its low cascade input, compute any 6-input function whose 64-entry truth table is the first slice's 32 bits followed above by the second slice's 32 bits.
- R10: After reset both truth tables hold 0 and the ready flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par_we | input | 1 | Parallel configuration write strobe |
| cfg_par_word | input | 32 | Parallel configuration word (table B above table A) |
| cfg_shift_en | input | 1 | Serial shift enable |
| cfg_sdi | input | 1 | Serial configuration bit |
| cfg_ok | output | 1 | Tables loaded and outputs valid |
| lut0_in | input | 4 | Table A inputs |
| lut1_in | input | 4 | Table B inputs |
| sel5 | input | 1 | Fifth input, picks table B when 1 |
| f0 | output | 1 | Table A output |
| f1 | output | 1 | Table B output |
| f5 | output | 1 | 5-input function output |
| fx_sel | input | 1 | Cascade select |
| fx_lo | input | 1 | Cascade input chosen when select is 0 |
| fx_hi | input | 1 | Cascade input chosen when select is 1 |
| fx_out | output | 1 | Cascade output |

## Verification
The bench builds the slice with its default of four inputs per table, which keeps each table at 16 entries, the slice at 32 configuration bits and a two-slice chain at 64 entries. That size puts exhaustive sweeps of every input combination within reach for the 4-, 5- and 6-input functions, each against random and directed truth tables. Serial loads of 31, 32 and 33 bits and a write that collides with shifting exercise the load-completion rules.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;

    // Default number of inputs per lookup table.
    localparam int DEF_K = 4;

    // Action chosen by the configuration store each cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_PAR   = 2'd1,
        ACT_SHIFT = 2'd2,
        ACT_CLOSE = 2'd3
    } cfg_act_e;

endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store
    import lut_slice_pkg::*;
#(
    parameter int K = DEF_K
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    par_we,
    input  logic [2*(1<<K)-1:0]     par_word,
    input  logic                    shift_en,
    input  logic                    sdi,
    output logic [(1<<K)-1:0]       tt_a,
    output logic [(1<<K)-1:0]       tt_b,
    output logic                    ok
);

    localparam int ENTRIES  = 1 << K;
    localparam int CFG_BITS = 2 * ENTRIES;
    localparam int CNT_W    = $clog2(CFG_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CFG_BITS + 1);

    typedef struct packed {
        logic [CFG_BITS-1:0] bits;
        logic [CNT_W-1:0]    cnt;
        logic                ok;
    } store_t;

    store_t   st_q, st_d;
    cfg_act_e act;

    always_comb begin
        if (par_we)
            act = ACT_PAR;
        else if (shift_en)
            act = ACT_SHIFT;
        else if (st_q.cnt != '0)
            act = ACT_CLOSE;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_PAR: begin
                st_d.bits = par_word;
                st_d.cnt  = '0;
                st_d.ok   = 1'b1;
            end
            ACT_SHIFT: begin
                st_d.bits = {sdi, st_q.bits[CFG_BITS-1:1]};
                st_d.ok   = 1'b0;
                if (st_q.cnt != CNT_SAT)
                    st_d.cnt = st_q.cnt + 1'b1;
            end
            ACT_CLOSE: begin
                st_d.ok  = (st_q.cnt == CNT_FULL);
                st_d.cnt = '0;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tt_a = st_q.bits[ENTRIES-1:0];
    assign tt_b = st_q.bits[CFG_BITS-1:ENTRIES];
    assign ok   = st_q.ok;

endmodule

// File: rtl/lut_table.sv
module lut_table #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tt,
    input  logic [K-1:0]      addr,
    output logic              y
);

    always_comb begin
        y = tt[addr];
    end

endmodule

// File: rtl/lut_mux2.sv
module lut_mux2 (
    input  logic a,
    input  logic b,
    input  logic s,
    output logic y
);

    always_comb begin
        y = s ? b : a;
    end

endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lut_slice_pkg::*;
#(
    parameter int K = DEF_K
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_par_we,
    input  logic [2*(1<<K)-1:0]     cfg_par_word,
    input  logic                    cfg_shift_en,
    input  logic                    cfg_sdi,
    output logic                    cfg_ok,
    input  logic [K-1:0]            lut0_in,
    input  logic [K-1:0]            lut1_in,
    input  logic                    sel5,
    output logic                    f0,
    output logic                    f1,
    output logic                    f5,
    input  logic                    fx_sel,
    input  logic                    fx_lo,
    input  logic                    fx_hi,
    output logic                    fx_out
);

    localparam int ENTRIES = 1 << K;
    localparam int N_LUT   = 2;

    logic [N_LUT-1:0][ENTRIES-1:0] tt_arr;
    logic [N_LUT-1:0][K-1:0]       addr_arr;
    logic [N_LUT-1:0]              raw;
    logic                          raw5;

    lut_cfg_store #(.K(K)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_we   (cfg_par_we),
        .par_word (cfg_par_word),
        .shift_en (cfg_shift_en),
        .sdi      (cfg_sdi),
        .tt_a     (tt_arr[0]),
        .tt_b     (tt_arr[1]),
        .ok       (cfg_ok)
    );

    assign addr_arr[0] = lut0_in;
    assign addr_arr[1] = lut1_in;

    for (genvar g = 0; g < N_LUT; g++) begin : g_lut
        lut_table #(.K(K)) u_tab (
            .tt   (tt_arr[g]),
            .addr (addr_arr[g]),
            .y    (raw[g])
        );
    end

    lut_mux2 u_mux5 (
        .a (raw[0]),
        .b (raw[1]),
        .s (sel5),
        .y (raw5)
    );

    lut_mux2 u_muxfx (
        .a (fx_lo),
        .b (fx_hi),
        .s (fx_sel),
        .y (fx_out)
    );

    assign f0 = cfg_ok & raw[0];
    assign f1 = cfg_ok & raw[1];
    assign f5 = cfg_ok & raw5;

endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_par_we,
    input logic cfg_shift_en,
    input logic cfg_ok,
    input logic sel5,
    input logic f0,
    input logic f1,
    input logic f5,
    input logic fx_sel,
    input logic fx_lo,
    input logic fx_hi,
    input logic fx_out
);

    // R3: configured 5-input output follows the table picked by sel5
    a_r3_f5_pick: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> (f5 == (sel5 ? f1 : f0)));

    // R4: cascade output follows the chosen cascade input
    a_r4_fx_pick: assert property (@(posedge clk) disable iff (!rst_n)
        fx_out == (fx_sel ? fx_hi : fx_lo));

    // R7: outputs held low while not configured
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (!f0 && !f1 && !f5));

    // R6: a shift cycle without a parallel write drops the ready flag
    a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_shift_en && !cfg_par_we) |=> !cfg_ok);

    // R5 and R8: parallel write raises the ready flag next cycle
    a_r5_par_ok: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_par_we |=> cfg_ok);

    // R5: ready flag holds while no load activity
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && !cfg_shift_en && !cfg_par_we) |=> cfg_ok);

endmodule

bind lut_slice lut_slice_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_par_we   (cfg_par_we),
    .cfg_shift_en (cfg_shift_en),
    .cfg_ok       (cfg_ok),
    .sel5         (sel5),
    .f0           (f0),
    .f1           (f1),
    .f5           (f5),
    .fx_sel       (fx_sel),
    .fx_lo        (fx_lo),
    .fx_hi        (fx_hi),
    .fx_out       (fx_out)
);

// File: tb/sim_lut_slice.sv
module sim_lut_slice;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // slice 0 (u0)
    logic        pw0 = 0, sh0 = 0, sdi0 = 0, s50 = 0, fxs0 = 0;
    logic [31:0] pwd0 = '0;
    logic [3:0]  a0 = '0, b0 = '0;
    logic        ok0, f00, f10, f50, fxo0;
    // slice 1 (u1)
    logic        pw1 = 0, s51 = 0;
    logic [31:0] pwd1 = '0;
    logic [3:0]  a1 = '0, b1 = '0;
    logic        ok1, f01, f11, f51, fxo1;
    logic        zero = 1'b0;

    lut_slice u0 (
        .clk(clk), .rst_n(rst_n), .cfg_par_we(pw0), .cfg_par_word(pwd0),
        .cfg_shift_en(sh0), .cfg_sdi(sdi0), .cfg_ok(ok0),
        .lut0_in(a0), .lut1_in(b0), .sel5(s50),
        .f0(f00), .f1(f10), .f5(f50),
        .fx_sel(fxs0), .fx_lo(f50), .fx_hi(f51), .fx_out(fxo0)
    );

    lut_slice u1 (
        .clk(clk), .rst_n(rst_n), .cfg_par_we(pw1), .cfg_par_word(pwd1),
        .cfg_shift_en(zero), .cfg_sdi(zero), .cfg_ok(ok1),
        .lut0_in(a1), .lut1_in(b1), .sel5(s51),
        .f0(f01), .f1(f11), .f5(f51),
        .fx_sel(zero), .fx_lo(zero), .fx_hi(zero), .fx_out(fxo1)
    );

    function automatic logic exp_lut4(input logic [15:0] tt, input logic [3:0] idx);
        return tt[idx];
    endfunction

    function automatic logic exp_lut5(input logic [31:0] w, input logic [4:0] idx);
        return idx[4] ? exp_lut4(w[31:16], idx[3:0]) : exp_lut4(w[15:0], idx[3:0]);
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic par_load0(input logic [31:0] w);
        @(negedge clk);
        pwd0 = w; pw0 = 1'b1;
        @(negedge clk);
        pw0 = 1'b0;
    endtask

    task automatic par_load1(input logic [31:0] w);
        @(negedge clk);
        pwd1 = w; pw1 = 1'b1;
        @(negedge clk);
        pw1 = 1'b0;
    endtask

    // shifts n bits of w (bit 0 first); leaves enable low for one edge
    task automatic ser_load0(input logic [31:0] w, input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi0 = w[i % 32]; sh0 = 1'b1;
            @(negedge clk);
            if (i == n / 2) begin
                a0 = 4'hF; b0 = 4'hF; s50 = 1'b0; #1;
                chk(ok0, 0, "R7 ready low mid-shift");
                chk({f00, f10, f50}, 0, "R7 outputs low mid-shift");
            end
        end
        sh0 = 1'b0;
        @(negedge clk);
    endtask

    // exhaustive LUT4 and LUT5 sweep on u0 against word w
    task automatic sweep0(input logic [31:0] w, input string tag);
        for (int x = 0; x < 16; x++) begin
            a0 = 4'(x); b0 = 4'(15 - x); #1;
            chk(f00, exp_lut4(w[15:0], 4'(x)), {"R1 table A ", tag});
            chk(f10, exp_lut4(w[31:16], 4'(15 - x)), {"R2 table B ", tag});
        end
        for (int x = 0; x < 32; x++) begin
            a0 = 4'(x); b0 = 4'(x); s50 = x[4]; #1;
            chk(f50, exp_lut5(w, 5'(x)), {"R3 lut5 ", tag});
        end
        s50 = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, w2;
        logic [63:0] big;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        a0 = 4'h5; b0 = 4'hA; #1;
        chk(ok0, 0, "R10 ready low in reset");
        chk({f00, f10, f50}, 0, "R10 outputs low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ok0, 0, "R10 ready low after reset");
        // configuration empty: a shift-free close never occurs; outputs low
        chk({f00, f10, f50}, 0, "R7 outputs low before load");

        // R4 cascade mux independent of configuration
        for (int x = 0; x < 8; x++) begin
            fxs0 = x[2];
            s50 = 1'b0; a0 = 4'h0;
            #1;
            chk(fxo0, fxs0 ? f51 : f50, "R4 cascade mux");
        end
        fxs0 = 1'b0;

        // directed corner tables
        par_load0(32'h0000_FFFF);
        chk(ok0, 1, "R5 ready after parallel write");
        sweep0(32'h0000_FFFF, "const");
        par_load0(32'h6996_8000);
        sweep0(32'h6996_8000, "and/parity");

        // random parallel tables
        for (int r = 0; r < 6; r++) begin
            w = $urandom;
            par_load0(w);
            chk(ok0, 1, "R5 ready after random write");
            sweep0(w, "random par");
            repeat (3) @(negedge clk);
            chk(ok0, 1, "R5 ready holds");
        end

        // serial loads of exactly 32 bits
        for (int r = 0; r < 3; r++) begin
            w = $urandom;
            ser_load0(w, 32);
            chk(ok0, 1, "R6 ready after 32 shifts");
            sweep0(w, "serial");
        end

        // short and long bursts leave the slice unconfigured
        ser_load0($urandom, 31);
        a0 = 4'hF; b0 = 4'hF; #1;
        chk(ok0, 0, "R7 ready low after 31 shifts");
        chk({f00, f10, f50}, 0, "R7 outputs low after 31 shifts");
        ser_load0($urandom, 33);
        chk(ok0, 0, "R7 ready low after 33 shifts");

        // parallel write collides with shifting
        w = $urandom;
        @(negedge clk);
        sh0 = 1'b1; sdi0 = 1'b1; pwd0 = w; pw0 = 1'b1;
        @(negedge clk);
        sh0 = 1'b0; pw0 = 1'b0;
        chk(ok0, 1, "R8 write wins over shift");
        sweep0(w, "R8 priority");

        // two-slice 6-input function
        for (int r = 0; r < 3; r++) begin
            w = $urandom; w2 = $urandom;
            par_load0(w);
            par_load1(w2);
            big = {w2, w};
            for (int x = 0; x < 64; x++) begin
                a0 = 4'(x); b0 = 4'(x); a1 = 4'(x); b1 = 4'(x);
                s50 = x[4]; s51 = x[4]; fxs0 = x[5]; #1;
                chk(fxo0, big[x], "R9 lut6 chain");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule